// File: doc/BRIEF.md
# Power-Gating Sequencer with State Retention

This controller sits in the always-on part of a chip and walks one switchable power domain between its powered and unpowered states. A sleep request starts the power-down walk. The walk gates the domain clock, optionally saves register state into retention storage, clamps the domain outputs, and then opens the power switch. A wake request runs the mirror walk. That walk closes the switch, optionally restores the saved state, releases the clamps and finally lets the clock run again.

Software issues sleep and wake requests as single-cycle pulses, produced by writes to a power control register. A configuration bit selects whether the save and restore steps are taken. Each step that depends on the domain waits for a handshake: power-good from the switch, or done from the retention logic. A programmable timeout catches a handshake that never comes. A wake request that arrives while the domain is still going down is remembered. It is acted on once the domain is fully off, so a walk is never cut short.

Top module: `pwrGateSeq`

## Requirements
- R1: After reset the state code is 0 (on), the clock enable is 1, the isolation enable is 0, the switch enable is 1, both strobes are 0 and the error flag is 0.
- R2: With retention on, a sleep pulse in the on state gives the following sequence, one step per clock edge. The clock enable drops and the code becomes 1 (going down). Next, the save strobe is high for exactly one cycle. Once the done input is seen, isolation rises. On the following edge the switch enable drops. Once power-good is seen low, the code becomes 2 (off).
- R3: With retention off, the power-down walk skips the save step: isolation rises on the edge after the clock is gated.
- R4: With retention on, a wake pulse in the off state gives the following sequence. The switch enable rises and the code becomes 3 (going up). After power-good is seen high, the restore strobe is high for exactly one cycle. After done is seen, isolation drops. On the following edge the clock enable rises and the code returns to 0.
- R5: With retention off, the power-up walk skips the restore step: isolation drops on the edge after power-good is seen high.
- R6: The save and restore strobes are single-cycle pulses. Neither is ever high in the same cycle as the clock enable.
- R7: A wake pulse during the power-down walk does not shorten that walk. The domain reaches code 2, and the power-up walk starts on the next edge without any further request.
- R8: When a waiting step sees no handshake for timeoutLimit+1 cycles after it is entered, the code becomes 4 and the error flag becomes 1. All domain outputs then hold their values, and all requests are ignored, until reset.
- R9: A sleep pulse outside the on state has no effect. A wake pulse in the on state or during the power-up walk has no effect.
- R10: The state code reads 0 for on, 1 for going down, 2 for off, 3 for going up and 4 for error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepReq | input | 1 | Single-cycle power-down request |
| wakeReq | input | 1 | Single-cycle power-up request |
| retainEn | input | 1 | 1 selects the save and restore steps |
| timeoutLimit | input | TMR_W | Handshake timeout, in cycles minus one |
| pwrGood | input | 1 | Switch status: 1 when domain supply is up |
| retDone | input | 1 | Pulse marking completion of a save or restore |
| clkEn | output | 1 | Domain clock enable |
| saveStb | output | 1 | Retention save strobe |
| restoreStb | output | 1 | Retention restore strobe |
| isoEn | output | 1 | Output clamp enable |
| pwrSwEn | output | 1 | Power switch enable |
| stateCode | output | 3 | Current phase encoding |
| errFlag | output | 1 | Handshake timeout occurred |

## Verification
The bench chases these corner cases:
- A wake pulse landing in each down step, including the edge where power-good falls. A design that dropped the pulse would stall in the off state. One that aborted the walk would skip the off state.
- Handshake delays of one and several cycles. These expose a sequencer that advances on a fixed count instead of on the handshake.
- A save handshake and a power-good handshake that never arrive. A design with an off-by-one timer would enter the error state a cycle early or late. A design that left the error state would move the switch or clamps.
- Requests given in the wrong phase. These must leave every output unchanged.

// File: rtl/pgsPkg.sv
package pgsPkg;

  typedef enum logic [3:0] {
    ST_ON, ST_DCLK, ST_DSAVE, ST_DISO, ST_DOFF,
    ST_OFF, ST_UON, ST_UREST, ST_UDEISO, ST_ERR
  } seqState_e;

  typedef struct packed {
    logic gateClk;
    logic ungateClk;
    logic setIso;
    logic clrIso;
    logic switchOff;
    logic switchOn;
    logic pulseSave;
    logic pulseRestore;
    logic loadTimer;
  } seqCmd_t;

  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] CODE_ON   = 3'd0;
  localparam logic [CODE_W-1:0] CODE_DOWN = 3'd1;
  localparam logic [CODE_W-1:0] CODE_OFF  = 3'd2;
  localparam logic [CODE_W-1:0] CODE_UP   = 3'd3;
  localparam logic [CODE_W-1:0] CODE_ERR  = 3'd4;

endpackage

// File: rtl/pgsCtrl.sv
module pgsCtrl
  import pgsPkg::*;
#(
  parameter int TMR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleepReq,
  input  logic              wakeReq,
  input  logic              retainEn,
  input  logic              pwrGood,
  input  logic              retDone,
  input  logic              timedOut,
  output seqCmd_t           cmd,
  output logic [CODE_W-1:0] stateCode,
  output logic              errFlag
);

  seqState_e state, nextState;
  logic      wakePend;
  logic      inDown;

  assign inDown = (state == ST_DCLK) || (state == ST_DSAVE) ||
                  (state == ST_DISO) || (state == ST_DOFF);

  always_comb begin
    nextState = state;
    cmd       = '0;
    unique case (state)
      ST_ON: if (sleepReq) begin
        nextState   = ST_DCLK;
        cmd.gateClk = 1'b1;
      end
      ST_DCLK: if (retainEn) begin
        nextState     = ST_DSAVE;
        cmd.pulseSave = 1'b1;
        cmd.loadTimer = 1'b1;
      end else begin
        nextState  = ST_DISO;
        cmd.setIso = 1'b1;
      end
      ST_DSAVE: if (retDone) begin
        nextState  = ST_DISO;
        cmd.setIso = 1'b1;
      end else if (timedOut) begin
        nextState = ST_ERR;
      end
      ST_DISO: begin
        nextState     = ST_DOFF;
        cmd.switchOff = 1'b1;
        cmd.loadTimer = 1'b1;
      end
      ST_DOFF: if (!pwrGood) begin
        nextState = ST_OFF;
      end else if (timedOut) begin
        nextState = ST_ERR;
      end
      ST_OFF: if (wakePend || wakeReq) begin
        nextState     = ST_UON;
        cmd.switchOn  = 1'b1;
        cmd.loadTimer = 1'b1;
      end
      ST_UON: if (pwrGood) begin
        if (retainEn) begin
          nextState        = ST_UREST;
          cmd.pulseRestore = 1'b1;
          cmd.loadTimer    = 1'b1;
        end else begin
          nextState  = ST_UDEISO;
          cmd.clrIso = 1'b1;
        end
      end else if (timedOut) begin
        nextState = ST_ERR;
      end
      ST_UREST: if (retDone) begin
        nextState  = ST_UDEISO;
        cmd.clrIso = 1'b1;
      end else if (timedOut) begin
        nextState = ST_ERR;
      end
      ST_UDEISO: begin
        nextState     = ST_ON;
        cmd.ungateClk = 1'b1;
      end
      ST_ERR: nextState = ST_ERR;
      default: nextState = ST_ERR;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_ON;
    else       state <= nextState;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                     wakePend <= 1'b0;
    else if (state == ST_OFF && nextState == ST_UON) wakePend <= 1'b0;
    else if (wakeReq && inDown)                    wakePend <= 1'b1;
  end

  always_comb begin
    unique case (state)
      ST_ON:                                  stateCode = CODE_ON;
      ST_DCLK, ST_DSAVE, ST_DISO, ST_DOFF:    stateCode = CODE_DOWN;
      ST_OFF:                                 stateCode = CODE_OFF;
      ST_UON, ST_UREST, ST_UDEISO:            stateCode = CODE_UP;
      default:                                stateCode = CODE_ERR;
    endcase
  end

  assign errFlag = (state == ST_ERR);

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERR) |=> (state == ST_ERR)); // R8
  AST_WAKE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (wakePend && state != ST_OFF) |=> wakePend); // R7
  AST_WAKE_SERVED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF && wakePend) |=> (state == ST_UON)); // R7
  AST_OFF_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF && !wakePend && !wakeReq) |=> (state == ST_OFF)); // R9
  AST_SAVE_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DSAVE && !retDone && timedOut) |=> (state == ST_ERR)); // R8

endmodule

// File: rtl/pgsDatapath.sv
module pgsDatapath
  import pgsPkg::*;
#(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCmd_t          cmd,
  input  logic [TMR_W-1:0] timeoutLimit,
  output logic             clkEn,
  output logic             saveStb,
  output logic             restoreStb,
  output logic             isoEn,
  output logic             pwrSwEn,
  output logic             timedOut
);

  localparam logic [TMR_W-1:0] CNT_MAX = {TMR_W{1'b1}};

  logic [TMR_W-1:0] waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkEn      <= 1'b1;
      isoEn      <= 1'b0;
      pwrSwEn    <= 1'b1;
      saveStb    <= 1'b0;
      restoreStb <= 1'b0;
    end else begin
      if (cmd.gateClk)        clkEn   <= 1'b0;
      else if (cmd.ungateClk) clkEn   <= 1'b1;
      if (cmd.setIso)         isoEn   <= 1'b1;
      else if (cmd.clrIso)    isoEn   <= 1'b0;
      if (cmd.switchOff)      pwrSwEn <= 1'b0;
      else if (cmd.switchOn)  pwrSwEn <= 1'b1;
      saveStb    <= cmd.pulseSave;
      restoreStb <= cmd.pulseRestore;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                waitCnt <= '0;
    else if (cmd.loadTimer)   waitCnt <= '0;
    else if (waitCnt != CNT_MAX) waitCnt <= waitCnt + 1'b1;
  end

  assign timedOut = (waitCnt == timeoutLimit);

  AST_SAVE_CLK_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (saveStb || restoreStb) |-> !clkEn); // R6
  AST_SAVE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    saveStb |=> !saveStb); // R6
  AST_RESTORE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    restoreStb |=> !restoreStb); // R6
  AST_ISO_BEFORE_CUT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwrSwEn) |-> (isoEn && !clkEn)); // R2
  AST_PWR_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(isoEn) |-> pwrSwEn); // R4
  AST_CLK_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkEn) |-> (!isoEn && pwrSwEn)); // R4

endmodule

// File: rtl/pwrGateSeq.sv
module pwrGateSeq
  import pgsPkg::*;
#(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sleepReq,
  input  logic             wakeReq,
  input  logic             retainEn,
  input  logic [TMR_W-1:0] timeoutLimit,
  input  logic             pwrGood,
  input  logic             retDone,
  output logic             clkEn,
  output logic             saveStb,
  output logic             restoreStb,
  output logic             isoEn,
  output logic             pwrSwEn,
  output logic [2:0]       stateCode,
  output logic             errFlag
);

  seqCmd_t seqCmd;
  logic    timedOut;

  pgsCtrl #(.TMR_W(TMR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sleepReq  (sleepReq),
    .wakeReq   (wakeReq),
    .retainEn  (retainEn),
    .pwrGood   (pwrGood),
    .retDone   (retDone),
    .timedOut  (timedOut),
    .cmd       (seqCmd),
    .stateCode (stateCode),
    .errFlag   (errFlag)
  );

  pgsDatapath #(.TMR_W(TMR_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .cmd          (seqCmd),
    .timeoutLimit (timeoutLimit),
    .clkEn        (clkEn),
    .saveStb      (saveStb),
    .restoreStb   (restoreStb),
    .isoEn        (isoEn),
    .pwrSwEn      (pwrSwEn),
    .timedOut     (timedOut)
  );

endmodule

// File: tb/pwrGateSeq_tb.sv
module pwrGateSeq_tb;

  localparam int TMR_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepReq = 1'b0;
  logic wakeReq = 1'b0;
  logic retainEn = 1'b1;
  logic [TMR_W-1:0] timeoutLimit = 8'd6;
  logic pwrGood = 1'b1;
  logic retDone = 1'b0;
  logic clkEn, saveStb, restoreStb, isoEn, pwrSwEn, errFlag;
  logic [2:0] stateCode;

  always #2.5 clk = ~clk;

  pwrGateSeq #(.TMR_W(TMR_W)) u_dut (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .wakeReq(wakeReq),
    .retainEn(retainEn), .timeoutLimit(timeoutLimit), .pwrGood(pwrGood),
    .retDone(retDone), .clkEn(clkEn), .saveStb(saveStb),
    .restoreStb(restoreStb), .isoEn(isoEn), .pwrSwEn(pwrSwEn),
    .stateCode(stateCode), .errFlag(errFlag)
  );

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  bit cmpEn = 1'b0;
  bit done = 1'b0;

  // domain environment
  int pgDelay = 2;
  int retDelay = 2;
  bit stuckPwr = 1'b0;
  bit stuckRet = 1'b0;
  int pgCnt = 0;
  int retCnt = 0;

  always @(negedge clk) begin
    if (pwrSwEn !== pwrGood && !stuckPwr) begin
      pgCnt++;
      if (pgCnt >= pgDelay) begin
        pwrGood = pwrSwEn;
        pgCnt = 0;
      end
    end else pgCnt = 0;
    retDone = 1'b0;
    if (retCnt > 0) begin
      retCnt--;
      if (retCnt == 0) retDone = 1'b1;
    end
    if ((saveStb || restoreStb) && !stuckRet) retCnt = retDelay;
  end

  // behavioural reference: phase numbers 0..9
  int ph = 0;
  int wt = 0;
  bit pend = 1'b0;
  bit eClk = 1'b1, eIso = 1'b0, ePwr = 1'b1, eSave = 1'b0, eRest = 1'b0;

  function automatic bit waitExpired();
    if (wt == int'(timeoutLimit)) return 1'b1;
    wt++;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      ph = 0; wt = 0; pend = 0;
      eClk = 1; eIso = 0; ePwr = 1; eSave = 0; eRest = 0;
    end else begin
      eSave = 0;
      eRest = 0;
      if (wakeReq && ph >= 1 && ph <= 4) pend = 1;
      case (ph)
        0: if (sleepReq) begin ph = 1; eClk = 0; end
        1: if (retainEn) begin ph = 2; eSave = 1; wt = 0; end
           else begin ph = 3; eIso = 1; end
        2: if (retDone) begin ph = 3; eIso = 1; end
           else if (waitExpired()) ph = 9;
        3: begin ph = 4; ePwr = 0; wt = 0; end
        4: if (!pwrGood) ph = 5;
           else if (waitExpired()) ph = 9;
        5: if (pend || wakeReq) begin ph = 6; ePwr = 1; wt = 0; pend = 0; end
        6: if (pwrGood) begin
             if (retainEn) begin ph = 7; eRest = 1; wt = 0; end
             else begin ph = 8; eIso = 0; end
           end else if (waitExpired()) ph = 9;
        7: if (retDone) begin ph = 8; eIso = 0; end
           else if (waitExpired()) ph = 9;
        8: begin ph = 0; eClk = 1; end
        default: ph = 9;
      endcase
    end
  end

  function automatic logic [2:0] expCode();
    if (ph == 0) return 3'd0;
    if (ph <= 4) return 3'd1;
    if (ph == 5) return 3'd2;
    if (ph <= 8) return 3'd3;
    return 3'd4;
  endfunction

  always @(negedge clk) begin
    if (cmpEn && rstN) begin
      logic [7:0] act, exp;
      act = {stateCode, errFlag, clkEn, isoEn, pwrSwEn, saveStb ^ restoreStb ? saveStb : saveStb};
      act = {stateCode, errFlag, clkEn, isoEn, pwrSwEn, saveStb};
      exp = {expCode(), ph == 9, eClk, eIso, ePwr, eSave};
      checks++;
      if (act !== exp || restoreStb !== eRest) begin
        errors++;
        $display("FAIL %s cycle compare: actual code/err/clk/iso/pwr/save=%b rest=%b expected %b rest=%b",
                 curReq, act, restoreStb, exp, eRest);
      end
    end
  end

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulseSleep();
    @(negedge clk) sleepReq = 1'b1;
    @(negedge clk) sleepReq = 1'b0;
  endtask

  task automatic pulseWake();
    @(negedge clk) wakeReq = 1'b1;
    @(negedge clk) wakeReq = 1'b0;
  endtask

  task automatic waitCode(input logic [2:0] code, input int maxCyc, input string req);
    bit hit = 1'b0;
    for (int i = 0; i < maxCyc && !hit; i++) begin
      @(negedge clk);
      if (stateCode == code) hit = 1'b1;
    end
    check(req, hit, stateCode, code);
  endtask

  task automatic doReset();
    @(negedge clk) rstN = 1'b0;
    stuckPwr = 0; stuckRet = 0;
    repeat (2) @(negedge clk);
    pwrGood = 1'b1;
    rstN = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cmpEn = 1'b1;
    @(negedge clk);
    // R1 reset values
    curReq = "R1";
    check("R1", stateCode == 3'd0 && clkEn && !isoEn && pwrSwEn && !saveStb &&
          !restoreStb && !errFlag, stateCode, 0);

    // R2/R4 with retention, delays 2
    curReq = "R2"; retainEn = 1; pulseSleep();
    check("R10", stateCode == 3'd1, stateCode, 1);
    waitCode(3'd2, 40, "R2");
    check("R2", !pwrSwEn && isoEn && !clkEn, {pwrSwEn, isoEn, clkEn}, 3'b010);
    curReq = "R9"; pulseSleep(); repeat (3) @(negedge clk);
    check("R9", stateCode == 3'd2 && !pwrSwEn, stateCode, 2);
    curReq = "R4"; pulseWake();
    check("R10", stateCode == 3'd3, stateCode, 3);
    curReq = "R9"; pulseWake();
    curReq = "R4"; waitCode(3'd0, 40, "R4");
    check("R4", clkEn && !isoEn && pwrSwEn, {clkEn, isoEn, pwrSwEn}, 3'b101);
    curReq = "R9"; pulseWake(); repeat (3) @(negedge clk);
    check("R9", stateCode == 3'd0 && clkEn, stateCode, 0);

    // R3/R5 without retention, fast handshakes
    pgDelay = 1; retDelay = 1;
    curReq = "R3"; retainEn = 0; pulseSleep();
    waitCode(3'd2, 40, "R3");
    curReq = "R5"; pulseWake();
    waitCode(3'd0, 40, "R5");

    // R7 wake during down walk, slow handshakes, at several offsets
    pgDelay = 3; retDelay = 4; retainEn = 1;
    for (int off = 0; off < 8; off += 2) begin
      curReq = "R7"; pulseSleep();
      repeat (off) @(negedge clk);
      pulseWake();
      waitCode(3'd2, 40, "R7");
      waitCode(3'd0, 40, "R7");
    end

    // R8 save handshake lost
    curReq = "R8"; stuckRet = 1; pulseSleep();
    waitCode(3'd4, 40, "R8");
    check("R8", errFlag && pwrSwEn && !clkEn, {errFlag, pwrSwEn, clkEn}, 3'b110);
    pulseWake(); pulseSleep(); repeat (4) @(negedge clk);
    check("R8", stateCode == 3'd4 && pwrSwEn && !isoEn, stateCode, 4);
    doReset();
    @(negedge clk);
    check("R1", stateCode == 3'd0 && clkEn && !errFlag, stateCode, 0);

    // R8 power-good lost on the way up
    curReq = "R8"; timeoutLimit = 8'd3; retainEn = 0; pulseSleep();
    waitCode(3'd2, 40, "R8");
    stuckPwr = 1; pulseWake();
    waitCode(3'd4, 20, "R8");
    repeat (4) @(negedge clk);
    check("R8", errFlag && pwrSwEn && isoEn && !clkEn, {errFlag, pwrSwEn, isoEn, clkEn}, 4'b1110);
    curReq = "R6";
    doReset();
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (done || cyc == 20000) begin
      if (!done) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule